// File: doc/BRIEF.md
# Gated Card Clock Divider

This block derives the clock for a memory-card bus from a fixed source clock by integer division. Software or a controller supplies a target frequency in hertz. The block converts it to the smallest divisor whose output rate does not exceed that target. Two conditions can override the result. A slow mode multiplies the divisor by a fixed ratio. A slow-start phase after power-up forces a fixed low rate until the first bulk transfer finishes.

The divider runs on a module clock at twice the nominal source rate. Each phase of the divided clock lasts `div + 1` module cycles, which gives an exact 50% duty cycle and a card-clock frequency of source / (div + 1). A new divisor is loaded only at the end of a high phase. The divider input is disabled for the one cycle in which the load happens and is re-enabled afterwards.

The output is gated off between transfers unless idle clocking is allowed or the slow-start phase is active. The gate changes only while the divided clock is low, so every pulse on the card clock is a complete one. The divisor occupies the low byte of a 16-bit register shared with another user. That user's upper byte is preserved.

Top module: `card_clk_gen`

## Requirements
- R1: On `req_load` the stored divisor becomes floor(SRC_HZ / (req_hz + 1)). This is the smallest d in 0..254 for which floor(SRC_HZ/(d+1)) <= req_hz. With the 50 MHz default: 25 MHz gives 1, 16 666 666 Hz gives 2, 400 kHz gives 124, 196 078 Hz gives 254, and 0xFFFFFFFF gives 0.
- R2: When no divisor in 0..254 satisfies the request, the stored divisor is 255. This is the minimum rate, source / 256. Example requests are 196 077 Hz and 100 kHz.
- R3: When `slow_req` is high and the slow-start phase is inactive, the applied divisor is the stored divisor times SLOW_MUL (default 8), saturated at 255.
- R4: During the slow-start phase the applied divisor is SRC_HZ / POST_HZ (50 by default), whatever the values of `slow_req` and the stored divisor.
- R5: A `pwr_up` pulse starts the slow-start phase, and it wins over a simultaneous `xfer_done`. A `xfer_done` pulse during the phase ends it. A `xfer_done` pulse outside the phase has no effect.
- R6: A divisor change is loaded only in the cycle after a high phase ends. In that cycle `div_in_en` is low for exactly one cycle, and `div_applied` changes only at the edge that ends that cycle.
- R7: When `idle_clk_en`, `xfer_active` and the slow-start phase are all low, `card_clk` stays low once the current pulse completes. When any of the three is high, pulses resume.
- R8: Every high pulse on `card_clk` lasts exactly `div_applied + 1` module cycles. There are no truncated pulses, and `card_clk` is never high while `div_in_en` is low.
- R9: `shared_word[15:8]` changes only on `hi_wr`, when it takes `hi_data`. `shared_word[7:0]` always equals `div_applied`.
- R10: After reset: `card_clk` is 0, `div_applied` is 255, `div_in_en` is 1, `shared_word` is 0x00FF, and the slow-start phase is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, twice the nominal source rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_hz | input | 32 | Requested card-clock frequency in Hz |
| req_load | input | 1 | Strobe: convert `req_hz` into the stored divisor |
| slow_req | input | 1 | Multiply the divisor by the slow ratio |
| pwr_up | input | 1 | Strobe: card power applied, start the slow-start phase |
| xfer_done | input | 1 | Strobe: a bulk transfer completed |
| idle_clk_en | input | 1 | Let the clock run while no transfer is active |
| xfer_active | input | 1 | A transfer is in progress |
| hi_wr | input | 1 | Write strobe for the upper byte of the shared register |
| hi_data | input | 8 | Upper-byte write data |
| card_clk | output | 1 | Gated, divided card clock |
| div_applied | output | 8 | Divisor currently in use by the divider |
| div_in_en | output | 1 | Divider input enable, low during a divisor load |
| shared_word | output | 16 | Shared register: upper byte preserved, divisor in the low byte |

## Verification
A wrong stored or forced divisor shows up on `div_applied` within one divided period after the request. That period is at most 512 module cycles. The same fault shows up as a wrong high-pulse width on `card_clk` at the next falling edge. A broken load handshake shows on the next divisor change: `div_applied` moves without a preceding single low cycle on `div_in_en`, or that cycle stretches. A broken gate or slow-start flag shows within one period: pulses appear on `card_clk` with every run condition low, or no pulses appear while a run condition is high.

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int SRC_HZ   = 50_000_000,
  parameter int POST_HZ  = 1_000_000,
  parameter int SLOW_MUL = 8,
  parameter int DIV_W    = 8,
  parameter int RATE_W   = 32
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RATE_W-1:0]    req_hz,
  input  logic                 req_load,
  input  logic                 slow_req,
  input  logic                 pwr_up,
  input  logic                 xfer_done,
  input  logic                 idle_clk_en,
  input  logic                 xfer_active,
  input  logic                 hi_wr,
  input  logic [DIV_W-1:0]     hi_data,
  output logic                 card_clk,
  output logic [DIV_W-1:0]     div_applied,
  output logic                 div_in_en,
  output logic [2*DIV_W-1:0]   shared_word
);
  localparam int DIV_MAX = (1 << DIV_W) - 1;
  localparam int DIV_TOP = DIV_MAX - 1;
  localparam int QW      = RATE_W + 1;
  localparam int MUL_W   = DIV_W + $clog2(SLOW_MUL + 1);
  localparam logic [DIV_W-1:0] POST_DIV = DIV_W'(SRC_HZ / POST_HZ);

  logic [DIV_W-1:0] div_store, div_q, cnt, div_calc, slow_div, target;
  logic [DIV_W-1:0] div_n, cnt_n, hi_q;
  logic             slow_phase, en_q, ph, gate_q, clk_q;
  logic             en_n, ph_n, gate_n, run, at_end;
  logic [QW-1:0]    quo;
  logic [MUL_W-1:0] prod;

  assign quo      = QW'(SRC_HZ) / ({1'b0, req_hz} + QW'(1));
  assign div_calc = (quo > QW'(DIV_TOP)) ? DIV_W'(DIV_MAX) : quo[DIV_W-1:0];
  assign prod     = MUL_W'(div_store) * MUL_W'(SLOW_MUL);
  assign slow_div = (prod > MUL_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : prod[DIV_W-1:0];
  assign target   = slow_phase ? POST_DIV : (slow_req ? slow_div : div_store);
  assign run      = idle_clk_en | slow_phase | xfer_active;
  assign at_end   = (cnt == div_q);

  always_comb begin
    div_n = div_q;
    en_n  = 1'b1;
    ph_n  = ph;
    cnt_n = cnt;
    if (!en_q) begin
      div_n = target;
      cnt_n = '0;
      ph_n  = 1'b0;
    end else if (ph && at_end && (target != div_q)) begin
      en_n  = 1'b0;
      cnt_n = '0;
      ph_n  = 1'b0;
    end else if (at_end) begin
      cnt_n = '0;
      ph_n  = ~ph;
    end else begin
      cnt_n = cnt + DIV_W'(1);
    end
    gate_n = ph_n ? gate_q : run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_store  <= DIV_W'(DIV_MAX);
      slow_phase <= 1'b0;
      div_q      <= DIV_W'(DIV_MAX);
      en_q       <= 1'b1;
      cnt        <= '0;
      ph         <= 1'b0;
      gate_q     <= 1'b0;
      clk_q      <= 1'b0;
      hi_q       <= '0;
    end else begin
      if (req_load) div_store <= div_calc;
      if (pwr_up) slow_phase <= 1'b1;
      else if (xfer_done) slow_phase <= 1'b0;
      div_q  <= div_n;
      en_q   <= en_n;
      cnt    <= cnt_n;
      ph     <= ph_n;
      gate_q <= gate_n;
      clk_q  <= ph_n & gate_n;
      if (hi_wr) hi_q <= hi_data;
    end
  end

  assign card_clk    = clk_q;
  assign div_applied = div_q;
  assign div_in_en   = en_q;
  assign shared_word = {hi_q, div_q};

  // R6
  load_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_applied) |-> !$past(div_in_en));
  // R6
  single_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_in_en |=> div_in_en);
  // R8
  no_clk_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk |-> div_in_en);
  // R8
  full_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> ($past(cnt) == $past(div_q)));
  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> !card_clk);
  // R4
  post_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_phase && !div_in_en) |=> (div_applied == POST_DIV));
  // R9
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(shared_word[2*DIV_W-1:DIV_W]));
endmodule

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_hz = '0;
  logic        req_load = 0, slow_req = 0, pwr_up = 0, xfer_done = 0;
  logic        idle_clk_en = 0, xfer_active = 1, hi_wr = 0;
  logic [7:0]  hi_data = '0;
  logic        card_clk, div_in_en;
  logic [7:0]  div_applied;
  logic [15:0] shared_word;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  int last_exp = 255;
  bit done = 0;

  always #4 clk = ~clk;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rst_n(rst_n), .req_hz(req_hz), .req_load(req_load),
    .slow_req(slow_req), .pwr_up(pwr_up), .xfer_done(xfer_done),
    .idle_clk_en(idle_clk_en), .xfer_active(xfer_active), .hi_wr(hi_wr),
    .hi_data(hi_data), .card_clk(card_clk), .div_applied(div_applied),
    .div_in_en(div_in_en), .shared_word(shared_word));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: divisor changes against the scoreboard, load handshake, pulse widths
  int prev_div = 255, hcnt = 0;
  bit prev_en = 1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (div_applied != 8'(prev_div)) begin
        if (exp_q.size() == 0)
          chk(0, "R6 unexpected divisor change", div_applied, prev_div);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(div_applied == 8'(e), t, div_applied, e);
        end
        chk(!prev_en, "R6 load without pause", prev_en, 0);
      end
      if (!div_in_en && !prev_en) chk(0, "R6 pause longer than one cycle", 0, 1);
      if (card_clk) hcnt++;
      else if (hcnt > 0) begin
        chk(hcnt == div_applied + 1, "R8 high pulse width", hcnt, div_applied + 1);
        hcnt = 0;
      end
      prev_div = div_applied;
      prev_en  = div_in_en;
    end
  end

  task automatic want(input int v, input string tag);
    if (v != last_exp) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
      last_exp = v;
    end
    for (int i = 0; i < 2000 && div_applied != 8'(v); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(div_applied == 8'(v), tag, div_applied, v);
  endtask

  task automatic load_rate(input logic [31:0] r);
    @(negedge clk); req_hz = r; req_load = 1;
    @(negedge clk); req_load = 0;
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    if (which == 0) pwr_up = 1;
    else if (which == 1) xfer_done = 1;
    else begin pwr_up = 1; xfer_done = 1; end
    @(negedge clk); pwr_up = 0; xfer_done = 0;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (card_clk) hi++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    // R10
    chk(card_clk == 0, "R10 card_clk", card_clk, 0);
    chk(div_applied == 255, "R10 div_applied", div_applied, 255);
    chk(div_in_en == 1, "R10 div_in_en", div_in_en, 1);
    chk(shared_word == 16'h00FF, "R10 shared_word", shared_word, 16'h00FF);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1
    load_rate(32'd25_000_000); want(1, "R1 25MHz");
    load_rate(32'd16_666_666); want(2, "R1 16.67MHz");
    load_rate(32'd400_000);    want(124, "R1 400kHz");
    load_rate(32'd196_078);    want(254, "R1 top divisor");
    // R2
    load_rate(32'd196_077);    want(255, "R2 just below range");
    load_rate(32'd100_000);    want(255, "R2 far below range");
    // R1
    load_rate(32'hFFFF_FFFF);  want(0, "R1 max request");

    // R3
    load_rate(32'd25_000_000); want(1, "R1 reload 25MHz");
    @(negedge clk); slow_req = 1; want(8, "R3 slow x8");
    load_rate(32'd400_000);    want(255, "R3 saturate");
    @(negedge clk); slow_req = 0; want(124, "R3 slow off");

    // R9
    @(negedge clk); hi_wr = 1; hi_data = 8'hA5;
    @(negedge clk); hi_wr = 0;
    chk(shared_word == 16'hA57C, "R9 upper write", shared_word, 16'hA57C);

    // R4, R5
    @(negedge clk); slow_req = 1; want(255, "R3 slow again");
    pulse_in(0);               want(50, "R4 post-power forced");
    repeat (600) @(negedge clk);
    chk(div_applied == 50, "R4 priority over slow", div_applied, 50);
    pulse_in(1);               want(255, "R5 phase ends");
    @(negedge clk); slow_req = 0; want(124, "R5 back to stored");
    pulse_in(1);
    repeat (600) @(negedge clk);
    chk(div_applied == 124, "R5 stray done ignored", div_applied, 124);
    pulse_in(2);               want(50, "R5 power-up wins");
    chk(shared_word[15:8] == 8'hA5, "R9 upper kept", shared_word[15:8], 8'hA5);

    // R7
    @(negedge clk); xfer_active = 0; idle_clk_en = 0;
    count_high(600, hi);
    chk(hi > 0, "R7 runs during slow start", hi, 1);
    pulse_in(1);               want(124, "R5 phase ends again");
    repeat (600) @(negedge clk);
    count_high(600, hi);
    chk(hi == 0, "R7 gated when idle", hi, 0);
    @(negedge clk); idle_clk_en = 1;
    count_high(600, hi);
    chk(hi > 0, "R7 idle clock allowed", hi, 1);
    @(negedge clk); idle_clk_en = 0;
    repeat (600) @(negedge clk);
    @(negedge clk); xfer_active = 1;
    count_high(600, hi);
    chk(hi > 0, "R7 restart on transfer", hi, 1);
    chk(exp_q.size() == 0, "R6 pending loads", exp_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule